// File: doc/BRIEF.md
# Multichannel Boxcar Averaging Filter

This block keeps a rolling mean of the latest samples for a set of analog-converter channels. One strobe from the converter, raised when a conversion round is finished, starts a sweep. The block then serves one filter slot per clock cycle. Each slot names the converter channel it reads through its own map entry. The slot takes that channel's newest right-aligned result and writes it over the oldest entry in the slot's circular buffer. It then adjusts the slot's running total by the difference and stores the total, shifted right by the log2 of the window, as the slot's filtered output.

All slots of one instance share the window length, which is a power of two from 1 to 64. A slot's output is marked valid once a full window of triggers has been taken since reset or restart. A completion flag can raise an interrupt at the end of each sweep. A trigger that arrives while a sweep is still running is dropped and recorded in an overrun flag. The host works through a flat register port with combinational reads. From that port it sets up the map, reads the filtered outputs and reads every raw sample still inside the window.

Top module: `boxcar_avg_top`

## Requirements
- R1: After reset, the following all read zero: the control register (0x000), the status register (0x001), every filtered output and every raw sample. `irq_o` and `valid_o` are low, and map entry s reads s.
- R2: During a sweep, `conv_sel_o` presents the map entry of the slot being served. The slot's sample is bits [SAMPLE_W-1:0] of `conv_data_i`, and the bits above are ignored.
- R3: When a sweep ends, each slot's output (read at 0x020+s) equals the sum of its last DEPTH samples, shifted right by WIN_LOG2. While fewer than DEPTH samples have been taken, the missing samples count as zero.
- R4: `valid_o` and status bit 2 stay low until DEPTH sweeps have completed since reset or restart, and are high from then on. Writing 1 to control bit 1 restarts the block: warm-up begins again, and all buffers, totals and outputs clear.
- R5: A sweep occupies SLOTS cycles after the trigger edge. If control bit 0 is set, the end of the sweep sets status bit 0. That flag drives `irq_o` and is cleared by writing 1 to status bit 0.
- R6: A trigger seen while a sweep is running starts no sweep and stores no sample. It sets status bit 1, which is cleared by writing 1 to it.
- R7: The raw sample from sweep n (counting from 0 after reset or restart) for slot s can be read at 0x400 + s*DEPTH + (n mod DEPTH). It stays there until the sweep DEPTH later overwrites it.
- R8: Map entry s at 0x010+s can be written and read back (CH_W bits). Addresses of slots that do not exist, and unused addresses, read zero.
- R9: Status bit 3 reads high while a sweep is in progress and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Conversion-round-complete strobe, one cycle |
| conv_sel_o | output | CH_W | Converter channel selected for the slot being served |
| conv_data_i | input | IN_W | Result word of the selected channel, right-aligned |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | 12 | Host register address |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data, combinational from the address |
| irq_o | output | 1 | Sweep-complete interrupt |
| valid_o | output | 1 | Warm-up finished, outputs represent full windows |

## Verification
The checker relies on two properties of the converter side. `conv_data_i` follows `conv_sel_o` within the same cycle, and it does not change while a sweep is running. Triggers are assumed to be one cycle wide. The bench meets these by modelling the converter as a lookup table indexed by `conv_sel_o`. It changes table contents only between sweeps and raises the trigger for exactly one cycle, except in the deliberate back-to-back overrun case. Restart writes are made only while the block is idle, so the sweep-length and valid-hold properties see no aborted sweeps.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;

  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 16;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 12'h000;
  localparam logic [REG_AW-1:0] ADDR_STAT = 12'h001;
  localparam logic [7:0]        PAGE_MAP  = 8'h01;
  localparam logic [7:0]        PAGE_OUT  = 8'h02;
  localparam logic [1:0]        PAGE_SMP  = 2'b01;

endpackage

// File: rtl/boxcar_seq.sv
module boxcar_seq #(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned WIN_LOG2 = 2,
  localparam int unsigned DEPTH   = 1 << WIN_LOG2,
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned PTR_W   = (WIN_LOG2 > 0) ? WIN_LOG2 : 1,
  localparam int unsigned FILL_W  = WIN_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              restart_i,
  input  logic              irq_en_i,
  input  logic              clr_done_i,
  input  logic              clr_ovr_i,
  output logic              busy_o,
  output logic              step_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              ovr_o
);
  import boxcar_pkg::*;

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [PTR_W-1:0]  PTR_LAST  = PTR_W'(DEPTH - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DEPTH);

  sweep_state_e      state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;
  logic              step, last;
  logic              seq_en, flag_en;

  always_comb begin
    step    = (state_q == ST_SWEEP) && !restart_i;
    last    = step && (slot_q == SLOT_LAST);
    state_d = state_q;
    slot_d  = slot_q;
    wptr_d  = wptr_q;
    fill_d  = fill_q;
    if (restart_i) begin
      state_d = ST_IDLE;
      slot_d  = '0;
      wptr_d  = '0;
      fill_d  = '0;
    end else if (state_q == ST_IDLE) begin
      if (trig_i) begin
        state_d = ST_SWEEP;
        slot_d  = '0;
      end
    end else if (last) begin
      state_d = ST_IDLE;
      slot_d  = '0;
      wptr_d  = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (fill_q != FILL_FULL) fill_d = fill_q + 1'b1;
    end else begin
      slot_d = slot_q + 1'b1;
    end
    seq_en = restart_i || step || (state_q == ST_IDLE && trig_i);

    done_d = done_q;
    if (clr_done_i) done_d = 1'b0;
    if (last && irq_en_i) done_d = 1'b1;

    ovr_d = ovr_q;
    if (clr_ovr_i) ovr_d = 1'b0;
    if (trig_i && (state_q == ST_SWEEP) && !restart_i) ovr_d = 1'b1;

    flag_en = clr_done_i || clr_ovr_i || last || trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      wptr_q  <= '0;
      fill_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      slot_q  <= slot_d;
      wptr_q  <= wptr_d;
      fill_q  <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (flag_en) begin
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  assign busy_o  = (state_q == ST_SWEEP);
  assign step_o  = step;
  assign slot_o  = slot_q;
  assign wptr_o  = wptr_q;
  assign valid_o = (fill_q == FILL_FULL);
  assign done_o  = done_q;
  assign ovr_o   = ovr_q;

endmodule

// File: rtl/boxcar_store.sv
module boxcar_store #(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned WIN_LOG2 = 2,
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned SUM_W    = 16,
  localparam int unsigned DEPTH   = 1 << WIN_LOG2,
  localparam int unsigned MEM_N   = SLOTS * DEPTH,
  localparam int unsigned MEM_AW  = (MEM_N > 1) ? $clog2(MEM_N) : 1,
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned PTR_W   = (WIN_LOG2 > 0) ? WIN_LOG2 : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                restart_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [PTR_W-1:0]    wptr_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [MEM_AW-1:0]   rd_mem_i,
  input  logic [SLOT_W-1:0]   rd_slot_i,
  output logic [SAMPLE_W-1:0] rd_sample_o,
  output logic [SAMPLE_W-1:0] rd_avg_o
);

  logic [SAMPLE_W-1:0] mem_q [MEM_N];
  logic [SUM_W-1:0]    sum_q [SLOTS];
  logic [SAMPLE_W-1:0] avg_q [SLOTS];

  logic [MEM_AW-1:0]   wr_addr;
  logic [SAMPLE_W-1:0] evict;
  logic [SUM_W-1:0]    sum_nx;
  logic [SAMPLE_W-1:0] avg_nx;

  always_comb begin
    wr_addr = MEM_AW'(int'(slot_i) * DEPTH + int'(wptr_i));
    evict   = mem_q[wr_addr];
    sum_nx  = sum_q[slot_i] - SUM_W'(evict) + SUM_W'(sample_i);
    avg_nx  = SAMPLE_W'(sum_nx >> WIN_LOG2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < MEM_N; e++) mem_q[e] <= '0;
    end else if (restart_i) begin
      for (int e = 0; e < MEM_N; e++) mem_q[e] <= '0;
    end else if (step_i) begin
      mem_q[wr_addr] <= sample_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        sum_q[s] <= '0;
        avg_q[s] <= '0;
      end
    end else if (restart_i) begin
      for (int s = 0; s < SLOTS; s++) begin
        sum_q[s] <= '0;
        avg_q[s] <= '0;
      end
    end else if (step_i) begin
      sum_q[slot_i] <= sum_nx;
      avg_q[slot_i] <= avg_nx;
    end
  end

  assign rd_sample_o = mem_q[rd_mem_i];
  assign rd_avg_o    = avg_q[rd_slot_i];

endmodule

// File: rtl/boxcar_regs.sv
module boxcar_regs #(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned CONV_CH  = 16,
  parameter int unsigned WIN_LOG2 = 2,
  parameter int unsigned SAMPLE_W = 10,
  localparam int unsigned DEPTH   = 1 << WIN_LOG2,
  localparam int unsigned MEM_N   = SLOTS * DEPTH,
  localparam int unsigned MEM_AW  = (MEM_N > 1) ? $clog2(MEM_N) : 1,
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CH_W    = (CONV_CH > 1) ? $clog2(CONV_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_i,
  input  logic [11:0]         reg_addr_i,
  input  logic [15:0]         reg_wdata_i,
  output logic [15:0]         reg_rdata_o,
  input  logic [SLOT_W-1:0]   cur_slot_i,
  output logic [CH_W-1:0]     conv_sel_o,
  output logic                irq_en_o,
  output logic                restart_o,
  output logic                clr_done_o,
  output logic                clr_ovr_o,
  input  logic                done_i,
  input  logic                ovr_i,
  input  logic                valid_i,
  input  logic                busy_i,
  output logic [MEM_AW-1:0]   rd_mem_o,
  output logic [SLOT_W-1:0]   rd_slot_o,
  input  logic [SAMPLE_W-1:0] rd_sample_i,
  input  logic [SAMPLE_W-1:0] rd_avg_i
);
  import boxcar_pkg::*;

  logic [CH_W-1:0] map_q [SLOTS];
  logic [CH_W-1:0] map_d [SLOTS];
  logic            irq_en_q, irq_en_d;
  logic            is_ctrl, is_stat, is_map, is_out, is_smp, slot_hit;
  logic [3:0]      sub_idx;
  logic [9:0]      smp_off;
  logic            map_we;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    sub_idx   = reg_addr_i[3:0];
    smp_off   = reg_addr_i[9:0];
    slot_hit  = int'(sub_idx) < SLOTS;
    is_ctrl   = (reg_addr_i == ADDR_CTRL);
    is_stat   = (reg_addr_i == ADDR_STAT);
    is_map    = (reg_addr_i[11:4] == PAGE_MAP) && slot_hit;
    is_out    = (reg_addr_i[11:4] == PAGE_OUT) && slot_hit;
    is_smp    = (reg_addr_i[11:10] == PAGE_SMP) && (int'(smp_off) < MEM_N);
    rd_slot_o = SLOT_W'(sub_idx);
    rd_mem_o  = MEM_AW'(smp_off);

    restart_o  = reg_wr_i && is_ctrl && reg_wdata_i[1];
    clr_done_o = reg_wr_i && is_stat && reg_wdata_i[0];
    clr_ovr_o  = reg_wr_i && is_stat && reg_wdata_i[1];
    irq_en_d   = (reg_wr_i && is_ctrl) ? reg_wdata_i[0] : irq_en_q;

    map_we = reg_wr_i && is_map;
    map_d  = map_q;
    if (map_we) map_d[rd_slot_o] = reg_wdata_i[CH_W-1:0];

    reg_rdata_o = '0;
    if (is_ctrl)     reg_rdata_o = {15'd0, irq_en_q};
    else if (is_stat) reg_rdata_o = {12'd0, busy_i, valid_i, ovr_i, done_i};
    else if (is_map) reg_rdata_o = 16'(map_q[rd_slot_o]);
    else if (is_out) reg_rdata_o = 16'(rd_avg_i);
    else if (is_smp) reg_rdata_o = 16'(rd_sample_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
    end else if (reg_wr_i && is_ctrl) begin
      irq_en_q <= irq_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) map_q[s] <= CH_W'(s % CONV_CH);
    end else if (map_we) begin
      map_q <= map_d;
    end
  end

  assign conv_sel_o = map_q[cur_slot_i];
  assign irq_en_o   = irq_en_q;

endmodule

// File: rtl/boxcar_avg_top.sv
module boxcar_avg_top #(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned CONV_CH  = 16,
  parameter int unsigned WIN_LOG2 = 2,
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned IN_W     = 16,
  parameter int unsigned SUM_W    = 16,
  localparam int unsigned DEPTH   = 1 << WIN_LOG2,
  localparam int unsigned MEM_N   = SLOTS * DEPTH,
  localparam int unsigned MEM_AW  = (MEM_N > 1) ? $clog2(MEM_N) : 1,
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned PTR_W   = (WIN_LOG2 > 0) ? WIN_LOG2 : 1,
  localparam int unsigned CH_W    = (CONV_CH > 1) ? $clog2(CONV_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  output logic [CH_W-1:0] conv_sel_o,
  input  logic [IN_W-1:0] conv_data_i,
  input  logic            reg_wr_i,
  input  logic [11:0]     reg_addr_i,
  input  logic [15:0]     reg_wdata_i,
  output logic [15:0]     reg_rdata_o,
  output logic            irq_o,
  output logic            valid_o
);

  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic                busy_w, step_w, restart_w, irq_en_w;
  logic                clr_done_w, clr_ovr_w, done_w, ovr_w;
  logic [SLOT_W-1:0]   slot_w, rd_slot_w;
  logic [PTR_W-1:0]    wptr_w;
  logic [MEM_AW-1:0]   rd_mem_w;
  logic [SAMPLE_W-1:0] sample_w, rd_sample_w, rd_avg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign sample_w = conv_data_i[SAMPLE_W-1:0];

  generate
    if (IN_W > SAMPLE_W) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^conv_data_i[IN_W-1:SAMPLE_W];
    end
  endgenerate

  boxcar_seq #(
    .SLOTS(SLOTS), .WIN_LOG2(WIN_LOG2)
  ) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .trig_i(trig_i), .restart_i(restart_w),
    .irq_en_i(irq_en_w), .clr_done_i(clr_done_w), .clr_ovr_i(clr_ovr_w),
    .busy_o(busy_w), .step_o(step_w), .slot_o(slot_w), .wptr_o(wptr_w),
    .valid_o(valid_o), .done_o(done_w), .ovr_o(ovr_w)
  );

  boxcar_store #(
    .SLOTS(SLOTS), .WIN_LOG2(WIN_LOG2), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)
  ) store_i (
    .clk(clk), .rst_n(rst_sync_n), .step_i(step_w), .restart_i(restart_w),
    .slot_i(slot_w), .wptr_i(wptr_w), .sample_i(sample_w),
    .rd_mem_i(rd_mem_w), .rd_slot_i(rd_slot_w),
    .rd_sample_o(rd_sample_w), .rd_avg_o(rd_avg_w)
  );

  boxcar_regs #(
    .SLOTS(SLOTS), .CONV_CH(CONV_CH), .WIN_LOG2(WIN_LOG2), .SAMPLE_W(SAMPLE_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cur_slot_i(slot_w),
    .conv_sel_o(conv_sel_o), .irq_en_o(irq_en_w), .restart_o(restart_w),
    .clr_done_o(clr_done_w), .clr_ovr_o(clr_ovr_w), .done_i(done_w),
    .ovr_i(ovr_w), .valid_i(valid_o), .busy_i(busy_w), .rd_mem_o(rd_mem_w),
    .rd_slot_o(rd_slot_w), .rd_sample_i(rd_sample_w), .rd_avg_i(rd_avg_w)
  );

  assign irq_o = done_w;

endmodule

// File: rtl/boxcar_avg_chk.sv
module boxcar_avg_chk #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              restart,
  input logic              busy,
  input logic [SLOT_W-1:0] slot,
  input logic              irq,
  input logic              valid,
  input logic              ovr
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  // R5: the interrupt can only rise on the edge that ends a sweep
  assert_irq_rise_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(busy) && !busy));

  // R5: a sweep proceeds one slot per cycle until the last slot
  assert_sweep_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (slot != SLOT_LAST) && !restart) |=>
      (busy && (slot == SLOT_W'($past(slot) + 1'b1))));

  // R4: once warm-up has ended, validity holds until a restart
  assert_valid_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !restart) |=> valid);

  // R2: the served slot never leaves the configured list
  assert_slot_in_list_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= SLOT_LAST));

  // R6: a trigger during a sweep always leaves the overrun flag set
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && !restart) |=> ovr);

endmodule

bind boxcar_avg_top boxcar_avg_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .trig(trig_i), .restart(restart_w),
  .busy(busy_w), .slot(slot_w), .irq(irq_o), .valid(valid_o), .ovr(ovr_w)
);

// File: tb/boxcar_avg_top_tb_top.sv
module boxcar_avg_top_tb_top;

  localparam int SLOTS = 4;
  localparam int DEPTH = 4;
  localparam int NVEC  = 8;
  localparam int MAPV [SLOTS] = '{3, 7, 0, 15};
  // one row per trigger: result word for slot 0..3 (upper bits exercise masking)
  localparam logic [15:0] VEC [NVEC][SLOTS] = '{
    '{16'd100, 16'd1023, 16'd0, 16'hFC05},
    '{16'd200, 16'd1023, 16'd1, 16'h8011},
    '{16'd300, 16'd1023, 16'd2, 16'd40},
    '{16'd400, 16'd1023, 16'd3, 16'hFFFF},
    '{16'd10,  16'd0,    16'd4, 16'd0},
    '{16'd20,  16'd0,    16'd5, 16'd0},
    '{16'd30,  16'd0,    16'd6, 16'd0},
    '{16'd40,  16'd0,    16'd7, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig;
  logic [3:0]  conv_sel;
  logic [15:0] conv_data;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq, valid;

  logic [15:0] conv_mem [16];
  int          hist [SLOTS][DEPTH];
  int          nsw;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  assign conv_data = conv_mem[conv_sel];

  boxcar_avg_top dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .conv_sel_o(conv_sel),
    .conv_data_i(conv_data), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq), .valid_o(valid)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic model_sweep();
    for (int s = 0; s < SLOTS; s++) hist[s][nsw % DEPTH] = int'(conv_mem[MAPV[s]] & 16'h03FF);
    nsw++;
  endtask

  function automatic int model_avg(input int s);
    int acc = 0;
    for (int k = 0; k < DEPTH; k++) acc += hist[s][k];
    return acc >> 2;
  endfunction

  task automatic set_row(input int v);
    for (int s = 0; s < SLOTS; s++) conv_mem[MAPV[s]] = VEC[v][s];
  endtask

  initial begin
    for (int c = 0; c < 16; c++) conv_mem[c] = 16'd0;
    for (int s = 0; s < SLOTS; s++) for (int k = 0; k < DEPTH; k++) hist[s][k] = 0;
    nsw = 0;
    trig = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    rd(12'h000, rv); check("R1 ctrl", rv, 0);
    rd(12'h001, rv); check("R1 status", rv, 0);
    check("R1 irq", irq, 0);
    check("R1 valid", valid, 0);
    for (int s = 0; s < SLOTS; s++) begin
      rd(12'(12'h020 + s), rv); check("R1 output", rv, 0);
      rd(12'(12'h010 + s), rv); check("R1 map default", rv, s);
      rd(12'(12'h400 + s * DEPTH), rv); check("R1 raw sample", rv, 0);
    end

    // R8: map programming and unused addresses
    for (int s = 0; s < SLOTS; s++) wr(12'(12'h010 + s), 16'(MAPV[s]));
    for (int s = 0; s < SLOTS; s++) begin
      rd(12'(12'h010 + s), rv); check("R8 map readback", rv, MAPV[s]);
    end
    rd(12'h014, rv); check("R8 absent slot", rv, 0);
    rd(12'h030, rv); check("R8 unused addr", rv, 0);

    // R2 R3 R4 R7: table walk
    for (int v = 0; v < NVEC; v++) begin
      set_row(v);
      pulse_trig();
      tick(SLOTS + 1);
      model_sweep();
      for (int s = 0; s < SLOTS; s++) begin
        rd(12'(12'h020 + s), rv); check("R3 filtered output", rv, model_avg(s));
        rd(12'(12'h400 + s * DEPTH + v % DEPTH), rv);
        check((s == 3) ? "R2 masked sample" : "R7 raw sample", rv, hist[s][v % DEPTH]);
      end
      check("R4 warm-up valid", valid, (v + 1 >= DEPTH) ? 1 : 0);
      rd(12'h001, rv); check("R4 status valid bit", rv[2], (v + 1 >= DEPTH) ? 1 : 0);
      check("R5 irq stays low when disabled", irq, 0);
      check("R9 idle busy bit", rv[3], 0);
    end
    for (int s = 0; s < SLOTS; s++)
      for (int k = 0; k < DEPTH; k++) begin
        rd(12'(12'h400 + s * DEPTH + k), rv); check("R7 window contents", rv, hist[s][k]);
      end

    // R5 R9: completion interrupt
    wr(12'h000, 16'h0001);
    rd(12'h000, rv); check("R5 irq enable readback", rv, 1);
    conv_mem[3] = 16'd777;
    pulse_trig();
    tick(1);
    check("R5 irq low mid-sweep", irq, 0);
    rd(12'h001, rv); check("R9 busy during sweep", rv[3], 1);
    tick(SLOTS);
    model_sweep();
    check("R5 irq after sweep", irq, 1);
    rd(12'h001, rv); check("R5 done status bit", rv[0], 1);
    wr(12'h001, 16'h0001);
    check("R5 irq cleared by W1C", irq, 0);
    rd(12'(12'h020), rv); check("R3 output after irq sweep", rv, model_avg(0));

    // R6: back-to-back trigger is dropped
    conv_mem[3] = 16'd555;
    pulse_trig();
    pulse_trig();
    rd(12'h001, rv);
    check("R6 overrun flag", rv[1], 1);
    check("R9 busy while overrun", rv[3], 1);
    tick(SLOTS + 2);
    model_sweep();
    rd(12'(12'h400 + (nsw % DEPTH)), rv); check("R6 no extra sample stored", rv, hist[0][nsw % DEPTH]);
    rd(12'(12'h020), rv); check("R6 single sweep output", rv, model_avg(0));
    wr(12'h001, 16'h0003);
    rd(12'h001, rv); check("R6 overrun cleared", rv[1], 0);
    check("R5 irq cleared again", irq, 0);

    // R4 R7: restart begins warm-up again
    wr(12'h000, 16'h0002);
    for (int s = 0; s < SLOTS; s++) for (int k = 0; k < DEPTH; k++) hist[s][k] = 0;
    nsw = 0;
    check("R4 valid cleared by restart", valid, 0);
    rd(12'h020, rv); check("R4 output cleared by restart", rv, 0);
    rd(12'h401, rv); check("R4 buffer cleared by restart", rv, 0);
    for (int t = 0; t < DEPTH; t++) begin
      conv_mem[3] = 16'(4 * (t + 1));
      pulse_trig();
      tick(SLOTS + 1);
      model_sweep();
      if (t == 0) begin
        rd(12'h400, rv); check("R7 pointer restarts at 0", rv, 4);
      end
      check("R4 valid after restart", valid, (t == DEPTH - 1) ? 1 : 0);
      rd(12'h020, rv); check("R3 output after restart", rv, model_avg(0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule